// File: doc/BRIEF.md
# USART Transmitter With Sync Fill

This block is the transmit half of a serial port. It takes a character from a host write into a one-entry holding register, moves it into a shift register at the next character boundary and sends it on `txd`. Every bit change follows a falling edge of the transmit clock `txc`. `txc` is sampled in the `clk` domain, and its falling edges pace the bit timer.

In asynchronous mode each character goes out as a framed word at `txc` divided by a selectable factor. In synchronous mode one bit leaves per falling edge of `txc` and there is no framing. Whenever no data character is waiting in synchronous mode, the block keeps the line busy with one or two programmed sync characters.

Transmission is gated by the clear-to-send input and an enable bit. A character accepted before the gate closes is still sent in full. A write made while the gate is closed is dropped. A break request forces the line low. All mode settings arrive as static inputs from the control sequencer.

Top module: `usart_tx`

## Requirements
- R1: After reset `txd` is 1 and `txe` is 1. `txrdy` is 0 while the gate is closed, and the holding register is empty.
- R2: An asynchronous frame is a 0 start bit, then 8 data bits LSB first, then an optional parity bit, then one stop bit (`two_stop`=0) or two stop bits (`two_stop`=1), all at 1. With `par_odd`=0 the parity bit makes the count of ones across data and parity even; with `par_odd`=1 it makes that count odd. The line idles at 1 between frames.
- R3: In asynchronous mode one bit lasts 1, 16 or 64 falling edges of `txc`, for `baud_sel` = 00, 01 or 10 (11 also selects 64). In synchronous mode each falling edge of `txc` starts a new bit. `txd` changes only after a `txc` falling edge.
- R4: The gate is open when `cts_n` is 0 and `tx_en` is 1. A write is accepted only while the gate is open, and `txrdy` is 1 exactly when the gate is open and the holding register is empty.
- R5: A character accepted before the gate closes is still sent completely.
- R6: A write made while the gate is closed is not sent, not even after the gate reopens, and `txe` stays 1.
- R7: `txe` is 0 while a data character sits in the holding register or in the shift register, and 1 otherwise.
- R8: In synchronous mode with the gate open and no data waiting, sync characters go out back to back, each 8 bits LSB first. With `two_sync`=1 they alternate between `sync_a` and `sync_b`, starting with `sync_a` after reset; with `two_sync`=0 only `sync_a` is sent. A waiting data character replaces the fill at the next character boundary. `txe` stays 1 during fill. With the gate closed and no data, the line idles at 1.
- R9: While `send_break` is 1, `txd` is 0.
- R10: `txrdy` falls in the cycle after an accepted write and rises again once the character has moved to the shift register. A write while the holding register is full is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| txc | input | 1 | Transmit clock; its falling edges pace the bits |
| sync_mode | input | 1 | 1 selects synchronous mode, 0 asynchronous |
| baud_sel | input | 2 | Asynchronous divide factor: 00 x1, 01 x16, 10/11 x64 |
| par_en | input | 1 | Append a parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| two_stop | input | 1 | Two stop bits instead of one (asynchronous) |
| two_sync | input | 1 | Alternate two sync characters in the fill |
| sync_a | input | 8 | First sync character |
| sync_b | input | 8 | Second sync character |
| tx_en | input | 1 | Transmit enable command bit |
| cts_n | input | 1 | Clear to send, active low |
| send_break | input | 1 | Force the line low |
| wr_stb | input | 1 | One-cycle write strobe for a new character |
| wr_data | input | 8 | Character to send |
| txd | output | 1 | Serial data out |
| txrdy | output | 1 | Holding register can take a character |
| txe | output | 1 | No data character left in the block |

## Verification
The hardest situation to reach is a data character landing in the middle of synchronous fill. Its arrival has to be placed relative to `txc` so that the character boundary where it takes over from the fill is known exactly. The bench generates `txc` itself and opens the gate in the same cycle as the first write, just after a rising edge of `txc`, so that data precedes any fill. It then makes a second write while a sync character is on the line, samples every bit after each falling edge and compares the stream bit for bit. A second hard case is closing the gate in the cycle after a write, before the character leaves the holding register. The bench covers it by raising `cts_n` directly after the strobe.

// File: rtl/usart_tx_pkg.sv
package usart_tx_pkg;

    localparam int DATA_W   = 8;
    localparam int STOP_MAX = 2;
    localparam int FRAME_W  = 1 + DATA_W + 1 + STOP_MAX;
    localparam int CNT_W    = $clog2(FRAME_W + 1);
    localparam int MAX_DIV  = 64;
    localparam int DIV_W    = $clog2(MAX_DIV);

    typedef enum logic [1:0] {
        BAUD_X1  = 2'b00,
        BAUD_X16 = 2'b01,
        BAUD_X64 = 2'b10,
        BAUD_XHI = 2'b11
    } baud_e;

    typedef struct packed {
        logic sync_mode;
        logic par_en;
        logic par_odd;
        logic two_stop;
    } frame_cfg_t;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [CNT_W-1:0]   len;
    } frame_t;

    function automatic int unsigned baud_div(input baud_e b);
        case (b)
            BAUD_X1:  return 1;
            BAUD_X16: return 16;
            default:  return MAX_DIV;
        endcase
    endfunction

    function automatic logic par_bit(input logic [DATA_W-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

    // Bits leave from index 0 upward; unused upper bits stay at mark level.
    function automatic frame_t build_frame(input logic [DATA_W-1:0] d, input frame_cfg_t c);
        frame_t f;
        int unsigned pos;
        f.bits = '1;
        pos = 0;
        if (!c.sync_mode) begin
            f.bits[0] = 1'b0;
            pos = 1;
        end
        for (int i = 0; i < DATA_W; i++) begin
            f.bits[pos + i] = d[i];
        end
        pos = pos + DATA_W;
        if (c.par_en) begin
            f.bits[pos] = par_bit(d, c.par_odd);
            pos = pos + 1;
        end
        if (!c.sync_mode) begin
            pos = pos + (c.two_stop ? 2 : 1);
        end
        f.len = CNT_W'(pos);
        return f;
    endfunction

endpackage

// File: rtl/tx_bit_timer.sv
module tx_bit_timer import usart_tx_pkg::*; (
    input  logic  clk,
    input  logic  rst,
    input  logic  txc,
    input  logic  sync_mode,
    input  baud_e baud,
    output logic  tick
);
    logic             txc_q;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] limit;
    logic             fall;

    assign limit = DIV_W'(baud_div(baud) - 1);
    assign fall  = txc_q & ~txc;
    assign tick  = fall & (sync_mode | (div_q == limit));

    always_ff @(posedge clk) begin
        if (rst) begin
            txc_q <= 1'b0;
            div_q <= '0;
        end else begin
            txc_q <= txc;
            if (fall) begin
                div_q <= (sync_mode || div_q == limit) ? '0 : div_q + 1'b1;
            end
        end
    end

    // R3: a bit step only ever follows a falling edge of txc
    a_r3_tick_after_fall: assert property (@(posedge clk) disable iff (rst)
        tick |-> (!txc && $past(txc)));

endmodule

// File: rtl/tx_hold_reg.sv
module tx_hold_reg import usart_tx_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data_q
);
    logic accept;

    assign accept = wr_stb & en & ~full;

    always_ff @(posedge clk) begin
        if (rst) begin
            full   <= 1'b0;
            data_q <= '0;
        end else if (accept) begin
            full   <= 1'b1;
            data_q <= wr_data;
        end else if (take) begin
            full   <= 1'b0;
        end
    end

    // R4: the register only fills from a write made while the gate is open
    a_r4_fill_needs_gate: assert property (@(posedge clk) disable iff (rst)
        $rose(full) |-> $past(wr_stb && en));

    // R5: a held character survives until the shifter takes it, gate or not
    a_r5_held_char_kept: assert property (@(posedge clk) disable iff (rst)
        (full && !take) |=> (full && $stable(data_q)));

endmodule

// File: rtl/tx_shifter.sv
module tx_shifter import usart_tx_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              en,
    input  frame_cfg_t        cfg,
    input  logic              two_sync,
    input  logic [DATA_W-1:0] sync_a,
    input  logic [DATA_W-1:0] sync_b,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    output logic              take,
    output logic              line_bit,
    output logic              data_busy
);
    logic [FRAME_W-1:0] sh_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               data_q;
    logic               sidx_q;
    logic               boundary;
    logic               fill;
    logic [DATA_W-1:0]  sync_char;
    frame_t             next_f;

    assign boundary  = (cnt_q <= CNT_W'(1));
    assign take      = tick & boundary & hold_full;
    assign fill      = tick & boundary & ~hold_full & cfg.sync_mode & en;
    assign sync_char = (two_sync && sidx_q) ? sync_b : sync_a;
    assign next_f    = build_frame(hold_full ? hold_data : sync_char, cfg);
    assign line_bit  = (cnt_q != '0) ? sh_q[0] : 1'b1;
    assign data_busy = data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '1;
            cnt_q  <= '0;
            data_q <= 1'b0;
            sidx_q <= 1'b0;
        end else if (tick) begin
            if (take || fill) begin
                sh_q   <= next_f.bits;
                cnt_q  <= next_f.len;
                data_q <= take;
                if (fill) begin
                    sidx_q <= two_sync ? ~sidx_q : 1'b0;
                end
            end else if (cnt_q > CNT_W'(1)) begin
                sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
                cnt_q <= cnt_q - 1'b1;
            end else begin
                sh_q   <= '1;
                cnt_q  <= '0;
                data_q <= 1'b0;
            end
        end
    end

    // R3: the bit position advances only on a bit step from the timer
    a_r3_cnt_only_on_tick: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt_q));

    // R2: a frame never claims more bits than the widest format holds
    a_r2_len_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(FRAME_W));

    // R8: the sync selector only moves while synchronous fill is in use
    a_r8_fill_only_sync: assert property (@(posedge clk) disable iff (rst)
        (sidx_q != $past(sidx_q)) |-> $past(cfg.sync_mode));

endmodule

// File: rtl/usart_tx.sv
module usart_tx import usart_tx_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              txc,
    input  logic              sync_mode,
    input  logic [1:0]        baud_sel,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic              two_sync,
    input  logic [DATA_W-1:0] sync_a,
    input  logic [DATA_W-1:0] sync_b,
    input  logic              tx_en,
    input  logic              cts_n,
    input  logic              send_break,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              txrdy,
    output logic              txe
);
    frame_cfg_t        fcfg;
    logic              gate;
    logic              tick;
    logic              take;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              line_bit;
    logic              data_busy;

    assign fcfg = '{sync_mode: sync_mode, par_en: par_en, par_odd: par_odd, two_stop: two_stop};
    assign gate = tx_en & ~cts_n;

    tx_bit_timer u_timer (
        .clk       (clk),
        .rst       (rst),
        .txc       (txc),
        .sync_mode (sync_mode),
        .baud      (baud_e'(baud_sel)),
        .tick      (tick)
    );

    tx_hold_reg u_hold (
        .clk     (clk),
        .rst     (rst),
        .en      (gate),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .take    (take),
        .full    (hold_full),
        .data_q  (hold_data)
    );

    tx_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .en        (gate),
        .cfg       (fcfg),
        .two_sync  (two_sync),
        .sync_a    (sync_a),
        .sync_b    (sync_b),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .take      (take),
        .line_bit  (line_bit),
        .data_busy (data_busy)
    );

    assign txd   = send_break ? 1'b0 : line_bit;
    assign txrdy = gate & ~hold_full;
    assign txe   = ~hold_full & ~data_busy;

    // R10: an accepted write closes txrdy on the next cycle
    a_r10_txrdy_drops: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && txrdy) |=> !txrdy);

    // R5: the shifter draws from the holding register only on a bit step
    a_r5_take_on_step: assert property (@(posedge clk) disable iff (rst)
        take |-> tick);

endmodule

// File: tb/tb_usart_tx.sv
module tb_usart_tx;

    typedef struct {
        logic [7:0] d;
        bit         par_en;
        bit         odd;
        bit         two_stop;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       txc = 1'b0;
    logic       sync_mode = 1'b0;
    logic [1:0] baud_sel = 2'b00;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       two_stop = 1'b0;
    logic       two_sync = 1'b0;
    logic [7:0] sync_a = 8'h16;
    logic [7:0] sync_b = 8'hE9;
    logic       tx_en = 1'b0;
    logic       cts_n = 1'b1;
    logic       send_break = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       txd;
    logic       txrdy;
    logic       txe;

    int   checks = 0;
    int   errors = 0;
    int   rx_count = 0;
    bit   mon_on = 1'b0;
    exp_t q[$];
    bit   bitq[$];

    usart_tx dut (
        .clk(clk), .rst(rst), .txc(txc), .sync_mode(sync_mode), .baud_sel(baud_sel),
        .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop), .two_sync(two_sync),
        .sync_a(sync_a), .sync_b(sync_b), .tx_en(tx_en), .cts_n(cts_n),
        .send_break(send_break), .wr_stb(wr_stb), .wr_data(wr_data),
        .txd(txd), .txrdy(txrdy), .txe(txe)
    );

    always #10 clk = ~clk;

    initial begin
        forever begin
            repeat (2) @(negedge clk);
            txc = ~txc;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int factor();
        return (baud_sel == 2'b00) ? 1 : (baud_sel == 2'b01) ? 16 : 64;
    endfunction

    // Driver: waits for room, writes, and records the frame the line must carry.
    task automatic send(input logic [7:0] d);
        exp_t e;
        while (!txrdy) @(negedge clk);
        e.d = d; e.par_en = par_en; e.odd = par_odd; e.two_stop = two_stop;
        q.push_back(e);
        wr_data = d;
        wr_stb  = 1'b1;
        @(negedge clk);
        wr_stb  = 1'b0;
        chk(txrdy == 1'b0, "R10", "txrdy after accepted write", txrdy, 0);
    endtask

    task automatic raw_write(input logic [7:0] d);
        wr_data = d;
        wr_stb  = 1'b1;
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    task automatic wait_idle();
        while (q.size() != 0 || !txe) @(negedge clk);
        repeat (16) @(negedge clk);
    endtask

    task automatic push_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) bitq.push_back(b[i]);
    endtask

    // Monitor: receives asynchronous frames by centre sampling and scores them.
    initial begin
        forever begin
            int         f;
            exp_t       e;
            logic [7:0] d;
            logic       st, p, s1, s2;
            @(negedge txd);
            if (!mon_on || send_break) continue;
            f = factor();
            if (q.size() != 0) e = q[0];
            else begin e.d = 8'h00; e.par_en = par_en; e.odd = par_odd; e.two_stop = two_stop; end
            repeat (2 * f) @(negedge clk);
            st = txd;
            for (int i = 0; i < 8; i++) begin
                repeat (4 * f) @(negedge clk);
                d[i] = txd;
            end
            p = 1'b0;
            if (e.par_en) begin
                repeat (4 * f) @(negedge clk);
                p = txd;
            end
            repeat (4 * f) @(negedge clk);
            s1 = txd;
            s2 = 1'b1;
            if (e.two_stop) begin
                repeat (4 * f) @(negedge clk);
                s2 = txd;
            end
            rx_count++;
            if (q.size() == 0) begin
                chk(1'b0, "R6", "unexpected frame on line", d, 0);
            end else begin
                e = q.pop_front();
                chk(st == 1'b0, "R2", "start bit", st, 0);
                chk(d == e.d, "R2", "data bits LSB first", d, e.d);
                if (e.par_en)
                    chk(p == ((^e.d) ^ e.odd), "R2", "parity bit", p, (^e.d) ^ e.odd);
                chk(s1 == 1'b1 && s2 == 1'b1, "R2", "stop bits", {s2, s1}, 3);
            end
        end
    end

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        int base;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(txd == 1'b1, "R1", "txd after reset", txd, 1);
        chk(txe == 1'b1, "R1", "txe after reset", txe, 1);
        chk(txrdy == 1'b0, "R1", "txrdy with gate closed", txrdy, 0);

        tx_en = 1'b1; cts_n = 1'b0;
        @(negedge clk);
        chk(txrdy == 1'b1, "R4", "txrdy with gate open", txrdy, 1);

        // async x1, 8N1, back to back
        mon_on = 1'b1;
        send(8'hA5);
        repeat (8) @(negedge clk);
        chk(txe == 1'b0, "R7", "txe while data queued", txe, 0);
        n = 0;
        while (!txrdy && n < 200) begin @(negedge clk); n++; end
        chk(txrdy == 1'b1, "R10", "txrdy back after move", txrdy, 1);
        send(8'h5A);
        wait_idle();
        chk(rx_count == 2, "R2", "frames received", rx_count, 2);
        chk(txe == 1'b1, "R7", "txe after last frame", txe, 1);
        chk(txd == 1'b1, "R2", "idle mark level", txd, 1);

        // R10: write while full is ignored
        base = rx_count;
        send(8'h33);
        raw_write(8'hCC);
        wait_idle();
        chk(rx_count == base + 1, "R10", "write while full ignored", rx_count - base, 1);

        // x16, even parity, two stops; start bit width
        baud_sel = 2'b01; par_en = 1'b1; par_odd = 1'b0; two_stop = 1'b1;
        send(8'hF1);
        @(negedge txd);
        @(negedge clk);
        n = 0;
        while (txd == 1'b0) begin n++; @(negedge clk); end
        chk(n == 64, "R3", "x16 start bit length in clk", n, 64);
        send(8'h3C);
        wait_idle();
        par_odd = 1'b1; two_stop = 1'b0;
        send(8'h01);
        wait_idle();

        // R5: gate closes right after the write
        baud_sel = 2'b00; par_en = 1'b0;
        base = rx_count;
        send(8'h96);
        cts_n = 1'b1;
        @(negedge clk);
        chk(txrdy == 1'b0, "R4", "txrdy with cts high", txrdy, 0);
        wait_idle();
        chk(rx_count == base + 1, "R5", "char before disable sent", rx_count - base, 1);

        // R6: write while closed is dropped
        raw_write(8'h69);
        repeat (200) @(negedge clk);
        chk(txe == 1'b1, "R6", "txe after closed write", txe, 1);
        chk(txd == 1'b1, "R6", "line idle after closed write", txd, 1);
        cts_n = 1'b0;
        repeat (200) @(negedge clk);
        chk(rx_count == base + 1, "R6", "dropped char never sent", rx_count - base, 1);
        chk(txe == 1'b1, "R6", "txe after reopen", txe, 1);

        // R9: break
        mon_on = 1'b0;
        send_break = 1'b1;
        n = 0;
        repeat (50) begin @(negedge clk); if (txd != 1'b0) n++; end
        chk(n == 0, "R9", "cycles high during break", n, 0);
        send_break = 1'b0;
        @(negedge clk);
        chk(txd == 1'b1, "R9", "line after break release", txd, 1);

        // R8: synchronous mode with fill
        tx_en = 1'b0;
        sync_mode = 1'b1; two_sync = 1'b1;
        repeat (8) @(negedge clk);
        push_byte(8'h4B); push_byte(sync_a); push_byte(sync_b); push_byte(sync_a);
        push_byte(8'hD2); push_byte(sync_b);
        @(posedge txc);
        tx_en = 1'b1;
        raw_write(8'h4B);
        for (int i = 0; i < 48; i++) begin
            bit b;
            @(negedge txc);
            @(negedge clk);
            b = bitq.pop_front();
            chk(txd == b, "R8", $sformatf("sync stream bit %0d", i), txd, b);
            if (i == 4)  chk(txe == 1'b0, "R7", "txe during sync data", txe, 0);
            if (i == 12) chk(txe == 1'b1, "R8", "txe during fill", txe, 1);
            if (i == 44) chk(txe == 1'b1, "R8", "txe during second fill", txe, 1);
            if (i == 24) raw_write(8'hD2);
            if (i == 28) chk(txe == 1'b0, "R7", "txe with data waiting", txe, 0);
        end

        // gate closed in sync mode: current char ends, line idles
        tx_en = 1'b0;
        repeat (12) @(negedge txc);
        n = 0;
        repeat (8) begin @(negedge txc); @(negedge clk); if (txd != 1'b1) n++; end
        chk(n == 0, "R8", "no fill with gate closed", n, 0);
        chk(txe == 1'b1, "R8", "txe with gate closed", txe, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule